// File: doc/BRIEF.md
# QPSK Pulse-Shaped Quadrature Modulator

This block turns a serial stream of data bits into a digital QPSK passband sample stream, producing one signed sample on every clock. Bits arrive one per handshake. They are grouped into pairs: the first bit of a pair drives the in-phase branch and the second drives the quadrature branch. Each branch level is +1 or -1. The levels enter two raised-cosine shaping filters once every eight clocks and zero on the seven clocks between. The filtered branches are then mixed onto a carrier running at one quarter of the clock.

At a quarter-rate carrier the cosine and sine take only the values 0 and ±1. The upmix therefore picks one filtered branch per sample and may negate it. If no complete bit pair is waiting when a symbol slot comes round, a zero symbol goes in. The sample stream never stalls, and an idle input makes the output settle to zero.

Top module: `qpsk_modulator`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it falls, `out_data` is 0 and `out_valid` is 0. `in_ready` is 1 while `rst` is high.
- R2: `in_ready` is 1 whenever fewer than two bits are held. A bit is taken on a rising edge where `in_valid` and `in_ready` are both 1. The first bit taken goes to the in-phase branch and the second to the quadrature branch. Once two bits are held, `in_ready` is 0 until the pair is consumed.
- R3: Bit value 0 maps to branch level +1 and bit value 1 maps to -1.
- R4: Number the rising edges after reset 0, 1, 2, and so on. A held pair is consumed only on an edge whose number is a multiple of 8. On such an edge with no complete pair, a zero symbol is inserted on both branches and any single held bit is kept.
- R5: Each branch is filtered by a symmetric 25-tap FIR fed with the zero-stuffed levels. By distance from the centre tap, the Q11 tap values are 1024, 994, 908, 777, 615, 439, 269, 119, 0, -81, -125, -137, -123. Each filter sum is clamped to the range -2047 to +2047.
- R6: Let the output after edge j use carrier quadrant j mod 4. Quadrants 0, 1, 2 and 3 give +I, -Q, -I and +Q respectively, where I and Q are the filter outputs.
- R7: The output after edge j is built from the branch levels inserted on edges j-2-k, for tap index k = 0..24. A symbol consumed on edge e therefore reaches the centre tap in the output after edge e+14.
- R8: `out_data` never takes the value -2048.
- R9: `out_valid` goes to 1 after edge 1 and stays 1 until the next reset.
- R10: When no bit has been taken for 35 or more edges, `out_data` is 0 and one sample is still produced on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | The block can take a bit this cycle |
| in_bit | input | 1 | Data bit |
| out_valid | output | 1 | Output stream is running |
| out_data | output | 12 | Signed Q11 passband sample |

## Verification
A slot counter that is off by any amount moves the edge on which pairs are consumed. This shows at `in_ready` within eight cycles and shifts every shaped pulse against the carrier. A wrong tap or branch sign corrupts the samples 2 to 26 cycles after the affected symbol. A wrong carrier phase shows within four samples as the wrong branch or the wrong sign appearing in a quadrant. A lost or duplicated bit in the pairing logic swaps branches for every later symbol, so it is caught at the next isolated-symbol peak.

// File: rtl/qpsk_modulator.sv
module qpsk_modulator #(
  parameter int SPS = 8,
  parameter int NTAPS = 25,
  parameter int DW = 12,
  parameter int PHASE_W = 10,
  parameter int unsigned FCW = 1 << (PHASE_W - 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_bit,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int CW  = $clog2(SPS);
  localparam int MID = (NTAPS - 1) / 2;
  localparam int AW  = DW + $clog2(NTAPS);
  localparam logic signed [AW-1:0] TOP = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] BOT = -TOP;

  logic [CW-1:0]      slot;
  logic [1:0]         held;
  logic               bit_i, bit_q;
  logic [NTAPS-1:0]   nz, ni, nq;
  logic [PHASE_W-1:0] ph;
  logic               v1;
  logic signed [AW-1:0] acc_i, acc_q;
  logic signed [DW-1:0] fi, fq;
  logic               take;

  function automatic logic signed [AW-1:0] coef(input int k);
    int d;
    d = (k > MID) ? k - MID : MID - k;
    case (d)
      0:  return AW'(1024);
      1:  return AW'(994);
      2:  return AW'(908);
      3:  return AW'(777);
      4:  return AW'(615);
      5:  return AW'(439);
      6:  return AW'(269);
      7:  return AW'(119);
      9:  return AW'(-81);
      10: return AW'(-125);
      11: return AW'(-137);
      12: return AW'(-123);
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > TOP) return TOP[DW-1:0];
    if (v < BOT) return BOT[DW-1:0];
    return v[DW-1:0];
  endfunction

  assign in_ready = (held != 2'd2);
  assign take     = (slot == '0) && (held == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= '0;
      held  <= '0;
      bit_i <= 1'b0;
      bit_q <= 1'b0;
      nz    <= '0;
      ni    <= '0;
      nq    <= '0;
    end else begin
      slot <= (slot == CW'(SPS - 1)) ? '0 : slot + 1'b1;
      if (take) begin
        held <= '0;
      end else if (in_valid && in_ready) begin
        if (held == 2'd0) bit_i <= in_bit;
        else              bit_q <= in_bit;
        held <= held + 1'b1;
      end
      nz <= {nz[NTAPS-2:0], take};
      ni <= {ni[NTAPS-2:0], take & bit_i};
      nq <= {nq[NTAPS-2:0], take & bit_q};
    end
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < NTAPS; k++) begin
      if (nz[k]) begin
        acc_i = ni[k] ? acc_i - coef(k) : acc_i + coef(k);
        acc_q = nq[k] ? acc_q - coef(k) : acc_q + coef(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fi        <= '0;
      fq        <= '0;
      ph        <= '0;
      v1        <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      fi        <= clamp(acc_i);
      fq        <= clamp(acc_q);
      ph        <= ph + PHASE_W'(FCW);
      v1        <= 1'b1;
      out_valid <= v1;
      case (ph[PHASE_W-1 -: 2])
        2'd0:    out_data <= fi;
        2'd1:    out_data <= -fq;
        2'd2:    out_data <= -fi;
        default: out_data <= fq;
      endcase
    end
  end
endmodule

// File: rtl/qpsk_modulator_chk.sv
module qpsk_modulator_chk #(
  parameter int DW = 12,
  parameter int QUIET = 35
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);
  logic [7:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || (in_valid && in_ready)) quiet <= '0;
    else if (quiet != 8'hFF)           quiet <= quiet + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_data == '0 && !out_valid && in_ready));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> $past(in_valid));

  assert_no_min_R8: assert property (@(posedge clk) disable iff (rst)
    out_data != {1'b1, {(DW-1){1'b0}}});

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(out_valid) |-> out_valid);

  assert_quiet_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 8'(QUIET)) |-> (out_data == '0));
endmodule

bind qpsk_modulator qpsk_modulator_chk #(.DW(DW), .QUIET(NTAPS + SPS + 2)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_qpsk_modulator.sv
`timescale 1ns/1ps
module test_qpsk_modulator;
  localparam int MAXE = 4096;
  // entry: [7]=I bit, [6]=Q bit, [5:0]=idle cycles afterwards
  localparam logic [7:0] VEC [0:11] = '{
    8'b00_000000, 8'b01_000000, 8'b10_000011, 8'b11_000000,
    8'b00_000101, 8'b11_010000, 8'b10_000000, 8'b01_000111,
    8'b01_000000, 8'b10_100000, 8'b00_000001, 8'b11_000000
  };

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_bit = 0;
  logic in_ready;
  logic out_valid;
  logic signed [11:0] out_data;

  int nchk = 0, nfail = 0;
  int e, mb, last_take, t;
  logic hb_i, hb_q, acc;
  int xi [0:MAXE-1];
  int xq [0:MAXE-1];
  int obs [0:MAXE-1];

  always #5 clk = ~clk;

  qpsk_modulator i_qpsk_modulator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int tapv(input int k);
    int d;
    d = (k > 12) ? k - 12 : 12 - k;
    case (d)
      0: return 1024;  1: return 994;   2: return 908;   3: return 777;
      4: return 615;   5: return 439;   6: return 269;   7: return 119;
      9: return -81;   10: return -125; 11: return -137; 12: return -123;
      default: return 0;
    endcase
  endfunction

  function automatic int satv(input int v);
    if (v > 2047) return 2047;
    if (v < -2047) return -2047;
    return v;
  endfunction

  function automatic int expect_out(input int j);
    int si, sq;
    si = 0; sq = 0;
    for (int k = 0; k < 25; k++) begin
      if (j - 2 - k >= 0) begin
        si += tapv(k) * xi[j-2-k];
        sq += tapv(k) * xq[j-2-k];
      end
    end
    si = satv(si); sq = satv(sq);
    case (j % 4)
      0: return si;
      1: return -sq;
      2: return -si;
      default: return sq;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, output logic ok);
    logic tk;
    in_valid = v;
    in_bit = b;
    check("R2 in_ready vs held bits", int'(in_ready), int'(mb < 2));
    tk = (e % 8 == 0) && (mb == 2);
    ok = v && (mb < 2);
    if (tk) begin
      xi[e] = hb_i ? -1 : 1;
      xq[e] = hb_q ? -1 : 1;
      mb = 0;
      last_take = e;
    end else if (ok) begin
      if (mb == 0) hb_i = b; else hb_q = b;
      mb++;
    end
    @(posedge clk);
    @(negedge clk);
    obs[e] = int'(out_data);
    check(e == 0 ? "R1 first edge sample" : "R6 R7 sample", int'(out_data), expect_out(e));
    check(e == 0 ? "R1 first edge valid" : "R9 out_valid", int'(out_valid), int'(e >= 1));
    check("R8 no -2048", int'(out_data == -12'sd2048), 0);
    e++;
  endtask

  task automatic send_bit(input logic b);
    logic ok;
    ok = 0;
    while (!ok) step(1'b1, b, ok);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    logic ok;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, ok);
  endtask

  task automatic do_reset();
    rst = 1;
    in_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 reset out_data", int'(out_data), 0);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset in_ready", int'(in_ready), 1);
    for (int i = 0; i < MAXE; i++) begin
      xi[i] = 0; xq[i] = 0; obs[i] = 0;
    end
    e = 0; mb = 0; last_take = -1;
    rst = 0;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();

    idle(40);
    for (int j = 0; j < 40; j++) check("R10 idle output zero", obs[j], 0);

    for (int n = 0; n < 12; n++) begin
      send_bit(VEC[n][7]);
      send_bit(VEC[n][6]);
      idle(int'(VEC[n][5:0]));
    end
    idle(40);
    check("R10 drained output zero", obs[e-1], 0);

    send_bit(1'b0);
    send_bit(1'b1);
    check("R2 ready low with pair held", int'(in_ready), 0);
    while (e % 8 != 1) idle(1);
    t = last_take;
    check("R4 pair taken on slot edge", t % 8, 0);
    while (e <= t + 16) idle(1);
    check("R3 R5 R7 centre peak of +I", obs[t+14], -1024);
    check("R3 R6 quadrant 3 carries +Q", obs[t+15], -994);
    check("R6 quadrant 0 carries +I", obs[t+16], 908);
    idle(40);

    send_bit(1'b1);
    t = e;
    idle(30);
    check("R2 ready high with one bit held", int'(in_ready), 1);
    for (int j = t; j < e; j++) check("R4 zero symbol while half pair held", obs[j], 0);
    send_bit(1'b0);
    idle(40);

    for (int n = 0; n < 4; n++) begin
      send_bit(n[0]);
      send_bit(n[1]);
    end
    idle(5);
    do_reset();
    idle(2);

    for (int n = 0; n < 20; n++) begin
      send_bit(((n * 3) % 4) >= 2);
      send_bit(((n * 3) % 2) == 1);
    end
    idle(40);
    check("R10 output returns to zero", obs[e-1], 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule